// File: doc/BRIEF.md
# SDRAM Command Timing Sequencer

This block turns one memory request into the SDRAM command sequence it needs, and it holds each gap between commands for a set number of memory clock cycles. A read or write opens the row with ACTIVE. After the row-to-column delay it issues READ or WRITE, then closes the bank with PRECHARGE and waits out the precharge time. A refresh request issues one AUTO REFRESH and then waits out the refresh time. Periodic refresh scheduling is done elsewhere and reaches the block as an ordinary request.

Three configuration fields set the gaps at run time. Each field encodes "value plus one" clocks. The row-to-column select picks 1 or 2 clocks; the 2-clock setting is made by placing one NOP in the gap. A mode input says whether the attached select pin drives SDRAM at all; when it does not, the chip select stays high. The configuration and the mode are captured when a request is accepted, so later changes do not affect a sequence that is already running.

Top module: `sdram_cmd_seq`

## Requirements
- R1: With `cfg_rcd`=0, the READ or WRITE command appears in the clock cycle right after ACTIVE.
- R2: With `cfg_rcd`=1, exactly one NOP appears between ACTIVE and READ or WRITE.
- R3: PRECHARGE follows READ or WRITE in the next cycle. After PRECHARGE come `cfg_rp` NOP cycles, and `done` is high `cfg_rp`+1 cycles after the PRECHARGE cycle.
- R4: A refresh request (`req_type`[1]=1) issues AUTO REFRESH, then `cfg_rfc` NOP cycles (0 to 7). `done` is high `cfg_rfc`+1 cycles after the AUTO REFRESH cycle.
- R5: The pins {cs_n,ras_n,cas_n,we_n} use these encodings: NOP=0111, ACTIVE=0011, READ=0101, WRITE=0100, PRECHARGE=0010, AUTO REFRESH=0001. `req_type`=00 is a read and 01 is a write. The idle state drives NOP.
- R6: `cmd_cs_n` stays 1 in every cycle when the SDRAM mode is off. The mode is the captured value during a sequence and the live `sdram_mode` while idle.
- R7: `req_ready` is high only while idle. A request is taken only when `req_valid` and `req_ready` are both high. A request made while busy is ignored and is not queued.
- R8: `cfg_rcd`, `cfg_rp`, `cfg_rfc` and `sdram_mode` are captured at acceptance. Changing them during a sequence does not alter its timing.
- R9: `done` is a one-cycle pulse. It comes in the first idle cycle after a sequence, together with `req_ready`.
- R10: ACTIVE carries the row on `mem_addr` and the bank on `mem_bank`. READ/WRITE carries the column (zero-extended) and the bank. PRECHARGE carries the bank with `mem_addr`=0. All other cycles drive 0 on both.
- R11: After reset the block is idle: `req_ready`=1, `done`=0, NOP on the pins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Memory clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sdram_mode | input | 1 | Select pin is in SDRAM mode when 1 |
| cfg_rcd | input | 1 | Row-to-column delay select (0: 1 clk, 1: 2 clk) |
| cfg_rp | input | 1 | Precharge time field (field+1 clocks) |
| cfg_rfc | input | 3 | Refresh time field (field+1 clocks) |
| req_valid | input | 1 | Request present |
| req_type | input | 2 | 00 read, 01 write, 1x refresh |
| req_bank | input | BANK_W | Bank of the access |
| req_row | input | ROW_W | Row of the access |
| req_col | input | COL_W | Column of the access |
| req_ready | output | 1 | High while idle |
| cmd_cs_n | output | 1 | Chip select, active low |
| cmd_ras_n | output | 1 | Row strobe, active low |
| cmd_cas_n | output | 1 | Column strobe, active low |
| cmd_we_n | output | 1 | Write enable, active low |
| mem_addr | output | max(ROW_W,COL_W) | Address bus |
| mem_bank | output | BANK_W | Bank address |
| done | output | 1 | End-of-sequence pulse |

## Verification
The bench builds the block with its default widths: 13-bit row, 10-bit column, 2-bit bank. These widths only affect the address path, so the sweep can cover every combination of the timing fields instead. It runs both delay selects, both precharge values, all eight refresh values, all three request types and both mode settings, and predicts each cycle's command, address, ready and done from the field values. Extra runs change the configuration and issue a second request in the middle of a sequence, to show that captured settings hold and that a busy request is dropped.

// File: rtl/sdram_cmd_seq.sv
module sdram_cmd_seq #(
  parameter int ROW_W  = 13,
  parameter int COL_W  = 10,
  parameter int BANK_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sdram_mode,
  input  logic              cfg_rcd,
  input  logic              cfg_rp,
  input  logic [2:0]        cfg_rfc,
  input  logic              req_valid,
  input  logic [1:0]        req_type,
  input  logic [BANK_W-1:0] req_bank,
  input  logic [ROW_W-1:0]  req_row,
  input  logic [COL_W-1:0]  req_col,
  output logic              req_ready,
  output logic              cmd_cs_n,
  output logic              cmd_ras_n,
  output logic              cmd_cas_n,
  output logic              cmd_we_n,
  output logic [((ROW_W > COL_W) ? ROW_W : COL_W)-1:0] mem_addr,
  output logic [BANK_W-1:0] mem_bank,
  output logic              done
);
  localparam int AW = (ROW_W > COL_W) ? ROW_W : COL_W;

  typedef enum logic [2:0] {
    S_IDLE, S_ACT, S_GAP, S_RW, S_PRE, S_REF, S_WAIT, S_DONE
  } st_t;

  st_t               st;
  logic [2:0]        cnt;
  logic              wr_q, rcd_q, rp_q, mode_q;
  logic [2:0]        rfc_q;
  logic [BANK_W-1:0] bank_q;
  logic [ROW_W-1:0]  row_q;
  logic [COL_W-1:0]  col_q;
  logic [3:0]        cmd;

  assign req_ready = (st == S_IDLE) || (st == S_DONE);
  assign done      = (st == S_DONE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      cnt    <= '0;
      wr_q   <= 1'b0;
      rcd_q  <= 1'b0;
      rp_q   <= 1'b0;
      rfc_q  <= '0;
      mode_q <= 1'b0;
      bank_q <= '0;
      row_q  <= '0;
      col_q  <= '0;
    end else begin
      case (st)
        S_IDLE, S_DONE: begin
          if (req_valid) begin
            wr_q   <= req_type[0];
            rcd_q  <= cfg_rcd;
            rp_q   <= cfg_rp;
            rfc_q  <= cfg_rfc;
            mode_q <= sdram_mode;
            bank_q <= req_bank;
            row_q  <= req_row;
            col_q  <= req_col;
            st     <= req_type[1] ? S_REF : S_ACT;
          end else begin
            st <= S_IDLE;
          end
        end
        S_ACT: st <= rcd_q ? S_GAP : S_RW;
        S_GAP: st <= S_RW;
        S_RW:  st <= S_PRE;
        S_PRE: begin
          cnt <= 3'd1;
          st  <= rp_q ? S_WAIT : S_DONE;
        end
        S_REF: begin
          cnt <= rfc_q;
          st  <= (rfc_q != 3'd0) ? S_WAIT : S_DONE;
        end
        S_WAIT: begin
          cnt <= cnt - 3'd1;
          if (cnt == 3'd1) st <= S_DONE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    case (st)
      S_ACT:   cmd = 4'b0011;
      S_RW:    cmd = wr_q ? 4'b0100 : 4'b0101;
      S_PRE:   cmd = 4'b0010;
      S_REF:   cmd = 4'b0001;
      default: cmd = 4'b0111;
    endcase
  end

  assign cmd_cs_n  = cmd[3] | ~(req_ready ? sdram_mode : mode_q);
  assign cmd_ras_n = cmd[2];
  assign cmd_cas_n = cmd[1];
  assign cmd_we_n  = cmd[0];

  assign mem_addr = (st == S_ACT) ? AW'(row_q) :
                    (st == S_RW)  ? AW'(col_q) : '0;
  assign mem_bank = (st == S_ACT || st == S_RW || st == S_PRE) ? bank_q : '0;
endmodule

// File: rtl/sdram_cmd_seq_chk.sv
module sdram_cmd_seq_chk (
  input logic clk,
  input logic rst_n,
  input logic sdram_mode,
  input logic req_ready,
  input logic done,
  input logic cs_n,
  input logic ras_n,
  input logic cas_n,
  input logic we_n
);
  logic [2:0] pins;
  assign pins = {ras_n, cas_n, we_n};

  assert_idle_nop_R7: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> pins == 3'b111);

  assert_done_ready_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> req_ready);

  assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_act_next_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (pins == 3'b011) |=> (pins == 3'b101 || pins == 3'b100 || pins == 3'b111));

  assert_gap_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (pins == 3'b011) ##1 (pins == 3'b111) |=> (pins == 3'b101 || pins == 3'b100));

  assert_rw_pre_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (pins == 3'b101 || pins == 3'b100) |=> pins == 3'b010);

  assert_cs_off_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (req_ready && !sdram_mode) |-> cs_n);
endmodule

bind sdram_cmd_seq sdram_cmd_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .sdram_mode(sdram_mode), .req_ready(req_ready),
  .done(done), .cs_n(cmd_cs_n), .ras_n(cmd_ras_n), .cas_n(cmd_cas_n),
  .we_n(cmd_we_n)
);

// File: tb/sdram_cmd_seq_test.sv
`timescale 1ns/1ps
module sdram_cmd_seq_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sdram_mode = 1'b1;
  logic        cfg_rcd = 1'b0, cfg_rp = 1'b0;
  logic [2:0]  cfg_rfc = 3'd0;
  logic        req_valid = 1'b0;
  logic [1:0]  req_type = 2'd0;
  logic [1:0]  req_bank = 2'd0;
  logic [12:0] req_row = '0;
  logic [9:0]  req_col = '0;
  logic        req_ready, cs_n, ras_n, cas_n, we_n, done;
  logic [12:0] mem_addr;
  logic [1:0]  mem_bank;

  int checks = 0, failures = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  sdram_cmd_seq uut (
    .clk(clk), .rst_n(rst_n), .sdram_mode(sdram_mode), .cfg_rcd(cfg_rcd),
    .cfg_rp(cfg_rp), .cfg_rfc(cfg_rfc), .req_valid(req_valid),
    .req_type(req_type), .req_bank(req_bank), .req_row(req_row),
    .req_col(req_col), .req_ready(req_ready), .cmd_cs_n(cs_n),
    .cmd_ras_n(ras_n), .cmd_cas_n(cas_n), .cmd_we_n(we_n),
    .mem_addr(mem_addr), .mem_bank(mem_bank), .done(done)
  );

  task automatic chk(input bit ok, input string rq, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", rq, act, exp, $time);
    end
  endtask

  task automatic run(input logic [1:0] t, input logic rcd, input logic rp,
                     input logic [2:0] rfc, input logic md,
                     input bit inj_cfg, input bit inj_req);
    logic [3:0]  ecmd;
    logic [12:0] eaddr;
    logic [1:0]  ebank;
    logic [12:0] row;
    logic [9:0]  col;
    logic [1:0]  bk;
    int len;
    bit rw;
    rw  = !t[1];
    len = rw ? 4 + rcd + rp : 2 + rfc;
    row = 13'h1000 ^ {rfc, rp, rcd, t, md, 5'h15};
    col = 10'h2A5 ^ {rfc, rp, rcd, 5'h0};
    bk  = {rcd, rp} ^ t;
    @(negedge clk);
    req_valid = 1'b1; req_type = t; req_bank = bk; req_row = row; req_col = col;
    cfg_rcd = rcd; cfg_rp = rp; cfg_rfc = rfc; sdram_mode = md;
    @(negedge clk);
    req_valid = 1'b0;
    for (int k = 1; k <= len + 1; k++) begin
      eaddr = '0; ebank = '0; ecmd = 4'b0111;
      if (k <= len) begin
        if (rw) begin
          if (k == 1) begin ecmd = 4'b0011; eaddr = row; ebank = bk; end
          else if (k == 2 + rcd) begin
            ecmd = t[0] ? 4'b0100 : 4'b0101; eaddr = {3'b0, col}; ebank = bk;
          end else if (k == 3 + rcd) begin ecmd = 4'b0010; ebank = bk; end
        end else if (k == 1) ecmd = 4'b0001;
      end
      if (!md) ecmd[3] = 1'b1;
      chk({cs_n, ras_n, cas_n, we_n} == ecmd,
          rw ? (k == 2 ? "R1/R2/R5 cmd" : "R3/R5 cmd") : "R4/R5 cmd",
          {cs_n, ras_n, cas_n, we_n}, ecmd);
      chk(!md ? cs_n : 1'b1, "R6 cs_n off", cs_n, 1);
      chk(mem_addr == eaddr && mem_bank == ebank, "R10 addr/bank",
          {mem_bank, mem_addr}, {ebank, eaddr});
      chk(done == (k == len), "R9 done", done, k == len);
      chk(req_ready == (k >= len), "R7 ready", req_ready, k >= len);
      if (k == 1) begin
        if (inj_cfg) begin
          cfg_rcd = ~rcd; cfg_rp = ~rp; cfg_rfc = ~rfc;
        end
        if (inj_req) begin
          req_valid = 1'b1; req_type = 2'b10;
        end
      end
      if (k == 2) req_valid = 1'b0;
      @(negedge clk);
    end
  endtask

  initial begin
    #20;
    chk(req_ready == 1'b1, "R11 ready", req_ready, 1);
    chk(done == 1'b0, "R11 done", done, 0);
    chk({cs_n, ras_n, cas_n, we_n} == 4'b0111, "R11 NOP", {cs_n, ras_n, cas_n, we_n}, 4'b0111);
    rst_n = 1'b1;
    for (int m = 0; m < 2; m++)
      for (int t = 0; t < 3; t++)
        for (int a = 0; a < 2; a++)
          for (int p = 0; p < 2; p++)
            for (int f = 0; f < 8; f++)
              run(2'(t), 1'(a), 1'(p), 3'(f), 1'(m), 1'b0, 1'b0);
    for (int t = 0; t < 3; t++) begin
      run(2'(t), 1'b0, 1'b1, 3'd2, 1'b1, 1'b1, 1'b0);  // R8
      run(2'(t), 1'b1, 1'b0, 3'd5, 1'b1, 1'b0, 1'b1);  // R7 busy request dropped
      run(2'(t), 1'b1, 1'b1, 3'd7, 1'b1, 1'b1, 1'b1);  // R8 and R7
    end
    @(negedge clk);
    sdram_mode = 1'b0;
    #1;
    chk(cs_n == 1'b1, "R6 idle cs_n", cs_n, 1);
    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #1000000;
    if (!finished) begin
      checks++; failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule